// File: doc/BRIEF.md
# Trace-Replay Bus Traffic Generator

This block replays a short list of behaviour records, held in an internal record store that is written through a load port, onto a simple valid/ready request bus with a single-bit response strobe. Each record is one of three kinds. A compute record becomes a timed wait. A non-blocking access issues a bus request and moves straight on. A blocking access issues a request and then halts the replay until its own response returns.

The wait for a compute record is the record's instruction count times a programmable cycles-per-instruction figure. That figure is fixed point with 4 fractional bits. The fractional part left over from each compute record is carried into the next one, so rounding error does not build up over a run. Responses return in request order. A counter of outstanding non-blocking requests tells the block which response belongs to a blocking access.

Two saturating counters can be read at any time. One holds model time: compute wait cycles plus blocking stall cycles. The other holds the stall cycles alone. A run starts on a `start` pulse and ends with `done`.

Top module: `trace_replay_gen`

## Requirements
- R1: Record kind code 0 is a compute block, 1 is a blocking access and 2 is a non-blocking access. Code 3 is skipped: it issues no request and adds no time.
- R2: A compute record waits floor((count × cpi + carry) / 16) cycles, where count is the record's data field and cpi has 4 fractional bits. The low 4 bits of that sum become the carry for the next compute record. A new run clears the carry, and a wait of zero cycles moves straight on.
- R3: A non-blocking access advances to the next record as soon as its request is accepted, without waiting for the response. It is held back only while the outstanding count is at its maximum.
- R4: A blocking access issues no later request until its own response arrives. Responses come back in order, so its response is the first one received after every earlier non-blocking response.
- R5: A memory request presents the record's address on `req_addr`, its data on `req_wdata`, and its operation bit on `req_write` (1 = write, 0 = read). All three stay stable while `req_valid` is high and `req_ready` is low. Requests appear in record order.
- R6: `stalled` counts the cycles from the one after a blocking request is accepted up to and including the cycle its response is sampled. `elapsed` equals the sum of all compute waits plus `stalled`. Neither counter decreases during a run.
- R7: `pending` is the number of non-blocking requests accepted but not yet answered. `done` rises only after the last record is handled and `pending` is zero, and it stays high until the next run starts.
- R8: `elapsed` and `stalled` saturate at their all-ones value.
- R9: `start` while a run is in progress has no effect. A response strobe when no response is expected changes neither `pending` nor the counters.
- R10: After reset, `busy`, `done`, `req_valid`, `pending`, `elapsed` and `stalled` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one record into the store |
| ld_idx | input | IDX_W | Record slot to write |
| ld_kind | input | 2 | Record kind code |
| ld_write | input | 1 | Operation bit for memory records |
| ld_addr | input | ADDR_W | Record address |
| ld_data | input | DATA_W | Write data, or instruction count for compute records |
| rec_count | input | IDX_W+1 | Number of records in the run (at most DEPTH) |
| cpi | input | CPI_W | Cycles per instruction, 4 fractional bits |
| start | input | 1 | Begin a run when idle |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_write | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | DATA_W | Request write data |
| rsp_valid | input | 1 | One in-order response |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with nothing outstanding |
| pending | output | PEND_W | Outstanding non-blocking requests |
| elapsed | output | TIME_W | Compute plus stall cycles |
| stalled | output | TIME_W | Blocking stall cycles |

## Verification
The outstanding counter can be raised by a newly accepted non-blocking request in the same cycle that it is lowered by the response to an earlier one. A blocking request can also be accepted in a cycle where an older non-blocking response lands. The bench provokes these overlaps with back-to-back non-blocking records, response latencies as short as one cycle, and several ready patterns. Every cycle it compares `pending` with its own count of open requests, and it checks the stall total against the due cycles its responder scheduled for each blocking access.

// File: rtl/trace_replay_gen.sv
module trace_replay_gen #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CPI_W  = 8,
  parameter int DEPTH  = 16,
  parameter int TIME_W = 32,
  parameter int PEND_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [$clog2(DEPTH)-1:0]   ld_idx,
  input  logic [1:0]                 ld_kind,
  input  logic                       ld_write,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic [DATA_W-1:0]          ld_data,
  input  logic [$clog2(DEPTH):0]     rec_count,
  input  logic [CPI_W-1:0]           cpi,
  input  logic                       start,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic                       req_write,
  output logic [ADDR_W-1:0]          req_addr,
  output logic [DATA_W-1:0]          req_wdata,
  input  logic                       rsp_valid,
  output logic                       busy,
  output logic                       done,
  output logic [PEND_W-1:0]          pending,
  output logic [TIME_W-1:0]          elapsed,
  output logic [TIME_W-1:0]          stalled
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ACC_W  = DATA_W + CPI_W;
  localparam int WAIT_W = ACC_W - 4;
  localparam logic [TIME_W-1:0] TMAX = '1;
  localparam logic [PEND_W-1:0] PMAX = '1;
  localparam logic [1:0] K_COMP = 2'd0;
  localparam logic [1:0] K_BLK  = 2'd1;
  localparam logic [1:0] K_NB   = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_COMP, S_ISSUE, S_BWAIT, S_DRAIN, S_DONE} st_t;

  logic [1:0]        kind_m [DEPTH];
  logic              wr_m   [DEPTH];
  logic [ADDR_W-1:0] addr_m [DEPTH];
  logic [DATA_W-1:0] data_m [DEPTH];

  st_t               st;
  logic [IDX_W:0]    pc;
  logic [3:0]        frac;
  logic [WAIT_W-1:0] wcnt;

  always_ff @(posedge clk)
    if (ld_en) begin
      kind_m[ld_idx] <= ld_kind;
      wr_m[ld_idx]   <= ld_write;
      addr_m[ld_idx] <= ld_addr;
      data_m[ld_idx] <= ld_data;
    end

  wire [IDX_W-1:0]  pc_ix    = pc[IDX_W-1:0];
  wire [1:0]        cur_kind = kind_m[pc_ix];
  wire [DATA_W-1:0] cur_data = data_m[pc_ix];
  wire [ACC_W-1:0]  acc      = ACC_W'(cur_data) * ACC_W'(cpi) + ACC_W'(frac);
  wire [WAIT_W-1:0] acc_cyc  = acc[ACC_W-1:4];

  assign req_valid = (st == S_ISSUE) && !(cur_kind == K_NB && pending == PMAX);
  assign req_write = wr_m[pc_ix];
  assign req_addr  = addr_m[pc_ix];
  assign req_wdata = cur_data;
  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);

  wire start_acc  = start && !busy;
  wire hs         = req_valid && req_ready;
  wire nb_issue   = hs && (cur_kind == K_NB);
  wire nb_retire  = rsp_valid && (pending != '0);
  wire blk_retire = rsp_valid && (pending == '0) && (st == S_BWAIT);
  wire tick_e     = (st == S_COMP) || (st == S_BWAIT);
  wire tick_s     = (st == S_BWAIT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      pc   <= '0;
      frac <= '0;
      wcnt <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st   <= S_FETCH;
            pc   <= '0;
            frac <= '0;
          end
        S_FETCH:
          if (pc == rec_count) st <= S_DRAIN;
          else begin
            case (cur_kind)
              K_COMP: begin
                frac <= acc[3:0];
                if (acc_cyc == '0) pc <= pc + 1'b1;
                else begin
                  wcnt <= acc_cyc;
                  st   <= S_COMP;
                end
              end
              K_BLK, K_NB: st <= S_ISSUE;
              default: pc <= pc + 1'b1;
            endcase
          end
        S_COMP: begin
          wcnt <= wcnt - 1'b1;
          if (wcnt == WAIT_W'(1)) begin
            pc <= pc + 1'b1;
            st <= S_FETCH;
          end
        end
        S_ISSUE:
          if (hs) begin
            if (cur_kind == K_NB) begin
              pc <= pc + 1'b1;
              st <= S_FETCH;
            end else st <= S_BWAIT;
          end
        S_BWAIT:
          if (blk_retire) begin
            pc <= pc + 1'b1;
            st <= S_FETCH;
          end
        S_DRAIN:
          if (pending == '0) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= '0;
    else        pending <= pending + PEND_W'(nb_issue) - PEND_W'(nb_retire);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      elapsed <= '0;
      stalled <= '0;
    end else if (start_acc) begin
      elapsed <= '0;
      stalled <= '0;
    end else begin
      if (tick_e && elapsed != TMAX) elapsed <= elapsed + 1'b1;
      if (tick_s && stalled != TMAX) stalled <= stalled + 1'b1;
    end
endmodule

// File: rtl/trace_replay_gen_chk.sv
module trace_replay_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TIME_W = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [PEND_W-1:0] pending,
  input logic [TIME_W-1:0] elapsed,
  input logic [TIME_W-1:0] stalled
);
  localparam logic [TIME_W-1:0] TMAX = '1;

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pending == '0 && !req_valid && !busy);

  p_pend_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pending == $past(pending) || pending == $past(pending) + 1'b1 || pending + 1'b1 == $past(pending));

  p_stall_le_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stalled <= elapsed);

  p_elapsed_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> elapsed >= $past(elapsed));

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(elapsed) == TMAX |-> elapsed == TMAX);

  p_idle_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind trace_replay_gen trace_replay_gen_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_W(TIME_W), .PEND_W(PEND_W)
) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .pending(pending),
  .elapsed(elapsed), .stalled(stalled)
);

// File: tb/trace_replay_gen_test.sv
module trace_replay_gen_test;
  localparam int ADDR_W = 16, DATA_W = 16, CPI_W = 8, DEPTH = 16, PEND_W = 4, IDX_W = 4;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0, ld_write = 0, start = 0, start_sat = 0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [1:0] ld_kind = '0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic [IDX_W:0] rec_count = '0;
  logic [CPI_W-1:0] cpi = 8'd16;
  logic req_ready = 0, rsp_valid = 0;
  logic req_valid, req_write, busy, done;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [PEND_W-1:0] pending;
  logic [31:0] elapsed, stalled;
  logic s_req_valid, s_req_write, s_busy, s_done;
  logic [ADDR_W-1:0] s_req_addr;
  logic [DATA_W-1:0] s_req_wdata;
  logic [PEND_W-1:0] s_pending;
  logic [7:0] s_elapsed, s_stalled;

  always #2.5 clk = ~clk;

  trace_replay_gen uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_kind(ld_kind),
    .ld_write(ld_write), .ld_addr(ld_addr), .ld_data(ld_data), .rec_count(rec_count),
    .cpi(cpi), .start(start), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .busy(busy), .done(done), .pending(pending),
    .elapsed(elapsed), .stalled(stalled));

  trace_replay_gen #(.TIME_W(8)) uut_sat (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_kind(ld_kind),
    .ld_write(ld_write), .ld_addr(ld_addr), .ld_data(ld_data), .rec_count(rec_count),
    .cpi(cpi), .start(start_sat), .req_valid(s_req_valid), .req_ready(1'b1),
    .req_write(s_req_write), .req_addr(s_req_addr), .req_wdata(s_req_wdata),
    .rsp_valid(1'b0), .busy(s_busy), .done(s_done), .pending(s_pending),
    .elapsed(s_elapsed), .stalled(s_stalled));

  int vectors = 0, miscompares = 0;
  int tk[16], tw[16], ta[16], td[16];
  int nrec = 0;
  int cyc = 0;
  int lat = 1, rdy_mode = 0;
  int q_due[64];
  bit q_nb[64];
  int qh = 0, qt = 0, last_due = 0;
  int nb_cnt = 0, max_nb = 0, mi = 0, mem_issued = 0;
  longint stall_sum = 0;
  bit blk_open = 0, inj = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_mem(int from);
    int f = from;
    while (f < nrec && !(tk[f] == 1 || tk[f] == 2)) f++;
    return f;
  endfunction

  function automatic int mem_total();
    int n = 0;
    for (int i = 0; i < nrec; i++) if (tk[i] == 1 || tk[i] == 2) n++;
    return n;
  endfunction

  task automatic set_rec(int i, int k, int w, int a, int d);
    tk[i] = k; tw[i] = w; ta[i] = a; td[i] = d;
  endtask

  task automatic load();
    for (int i = 0; i < nrec; i++) begin
      @(negedge clk);
      ld_en = 1; ld_idx = IDX_W'(i); ld_kind = 2'(tk[i]); ld_write = tw[i][0];
      ld_addr = ADDR_W'(ta[i]); ld_data = DATA_W'(td[i]);
    end
    @(negedge clk);
    ld_en = 0;
    rec_count = (IDX_W+1)'(nrec);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    chk("R7", "pending vs open non-blocking", pending, nb_cnt);
    if (blk_open && req_valid) chk("R4", "request while blocking open", 1, 0);
    if (done && qh != qt) chk("R7", "done with responses owed", 1, 0);
    case (rdy_mode)
      0: req_ready = 1;
      1: req_ready = (cyc % 3) != 0;
      default: req_ready = (cyc % 4) == 3;
    endcase
    rsp_valid = 0;
    if (inj) begin
      rsp_valid = 1; inj = 0;
    end else if (qh != qt && q_due[qh % 64] == cyc + 1) begin
      rsp_valid = 1;
      if (q_nb[qh % 64]) nb_cnt--; else blk_open = 0;
      qh++;
    end
    if (req_valid && req_ready) begin
      int due;
      if (mi >= nrec) chk("R5", "unexpected request", 1, 0);
      else begin
        chk("R5", "addr", req_addr, ta[mi]);
        chk("R5", "write bit", req_write, tw[mi]);
        chk("R5", "wdata", req_wdata, td[mi]);
      end
      due = cyc + 1 + lat;
      if (due <= last_due) due = last_due + 1;
      last_due = due;
      q_due[qt % 64] = due;
      q_nb[qt % 64] = (mi < nrec) && tk[mi] == 2;
      if (q_nb[qt % 64]) begin
        nb_cnt++;
        if (nb_cnt > max_nb) max_nb = nb_cnt;
      end else begin
        blk_open = 1;
        stall_sum += due - (cyc + 1);
      end
      qt++;
      mem_issued++;
      mi = next_mem(mi + 1);
    end
  end

  task automatic run(int cpi_v, int lat_v, int mode_v, bit mid_start, string tag);
    longint prod = 0;
    int t = 0;
    lat = lat_v; rdy_mode = mode_v; cpi = CPI_W'(cpi_v);
    stall_sum = 0; max_nb = 0; mem_issued = 0; mi = next_mem(0);
    for (int i = 0; i < nrec; i++) if (tk[i] == 0) prod += longint'(td[i]) * cpi_v;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
      start = mid_start && (t == 5);
    end
    start = 0;
    chk(tag, "finished before timeout", t < 20000, 1);
    chk("R6", "stalled", stalled, stall_sum);
    chk("R6", "elapsed", elapsed, prod / 16 + stall_sum);
    chk("R5", "requests issued", mem_issued, mem_total());
    chk("R7", "pending at done", pending, 0);
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int cpis[6] = '{16, 24, 5, 1, 37, 0};
    int lats[4] = '{1, 2, 5, 9};
    longint e0;
    repeat (3) @(negedge clk);
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "req_valid", req_valid, 0);
    chk("R10", "pending", pending, 0);
    chk("R10", "elapsed", elapsed, 0);
    chk("R10", "stalled", stalled, 0);
    rst_n = 1;
    @(negedge clk);

    // R7: empty trace finishes with zero time
    nrec = 0; load();
    run(16, 1, 0, 0, "R7");

    // R1 R2: compute-only sweep with carry
    nrec = 5;
    set_rec(0, 0, 0, 0, 3); set_rec(1, 0, 0, 0, 3); set_rec(2, 0, 0, 0, 7);
    set_rec(3, 0, 0, 0, 0); set_rec(4, 0, 0, 0, 10);
    load();
    foreach (cpis[i]) run(cpis[i], 1, 0, 0, "R2");

    // R3 R4 R5 R6 R7: mixed trace over latencies and ready patterns
    nrec = 11;
    set_rec(0, 0, 0, 0, 4);
    set_rec(1, 2, 1, 'h100, 'h11);
    set_rec(2, 2, 0, 'h104, 0);
    set_rec(3, 1, 1, 'h108, 'h22);
    set_rec(4, 0, 0, 0, 3);
    set_rec(5, 2, 1, 'h10c, 'h33);
    set_rec(6, 1, 0, 'h110, 0);
    set_rec(7, 2, 1, 'h114, 'h44);
    set_rec(8, 2, 0, 'h118, 0);
    set_rec(9, 0, 0, 0, 2);
    set_rec(10, 2, 1, 'h11c, 'h55);
    load();
    foreach (lats[li]) for (int m = 0; m < 3; m++) begin
      run(20, lats[li], m, 0, "R4");
      if (lats[li] >= 5 && m == 0) chk("R3", "two non-blocking open at once", max_nb >= 2, 1);
    end

    // R9: start during a run is ignored
    run(20, 5, 1, 1, "R9");
    // R7: done held
    repeat (5) @(negedge clk);
    chk("R7", "done held", done, 1);
    // R9: stray response while idle
    e0 = elapsed;
    inj = 1;
    repeat (3) @(negedge clk);
    chk("R9", "pending after stray response", pending, 0);
    chk("R9", "elapsed after stray response", elapsed, e0);
    chk("R9", "done after stray response", done, 1);

    // R1: kind 3 skipped
    nrec = 3;
    set_rec(0, 0, 0, 0, 5);
    set_rec(1, 3, 1, 'h200, 'h99);
    set_rec(2, 2, 1, 'h204, 7);
    load();
    run(16, 2, 0, 0, "R1");

    // R8: saturation in an 8-bit instance, unsaturated in the main one
    nrec = 1;
    set_rec(0, 0, 0, 0, 100);
    load();
    cpi = 8'd48;
    @(negedge clk); start_sat = 1;
    @(negedge clk); start_sat = 0;
    run(48, 1, 0, 0, "R8");
    repeat (3) @(negedge clk);
    chk("R8", "saturated elapsed", s_elapsed, 255);
    chk("R8", "saturated run done", s_done, 1);
    chk("R8", "saturated stalled", s_stalled, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule